// File: doc/BRIEF.md
# Interrupt Status Flags with Two-Way Clear

This block holds the event flags of one peripheral and turns them into an interrupt request for the processor. Each hardware event input sets a sticky flag bit. A request leaves the block only while at least one flag is set together with its enable input and the processor's global mask bit is clear. A flag that is set but masked stays latched until it is either serviced or cleared.

Software clears flags over a small register bus in one of two ways. It can write the status register with a zero in each bit to be cleared. It can also read the status register and then access the peripheral's data register. The second method clears only the flags that were set at the moment of the status read. Clearing a flag always discards any request it was holding back, so a later enable does not bring that request back.

Top module: `isf_status_flags`

## Requirements
- R1: After reset every flag is clear and `irq_o` is low; a reset pulse in mid-operation also discards all flags.
- R2: An event pulse on `evt_i[k]` sets flag k at the next clock edge, and a later status read returns it in bit k.
- R3: `irq_o` is high exactly when some flag k is set with `en_i[k]` high while `ibit_i` is low.
- R4: A flag whose enable is low, or that is set while `ibit_i` is high, stays set; raising the enable or lowering `ibit_i` then raises `irq_o`.
- R5: A write to the status address (address 0) clears each flag whose write-data bit is 0 and leaves flags whose bit is 1 unchanged; software can never set a flag.
- R6: A status read followed by a read or a write of the data address (address 1) clears the flags that were set at that status read; a status write with all ones in between does not cancel this.
- R7: A flag that is set after the status read is not cleared by the following data access.
- R8: A data access that is not preceded by a status read clears nothing, and one status read allows only one data access to clear flags.
- R9: When an event and a software clear (of either kind) hit the same flag in the same cycle, the flag ends up set.
- R10: Once a flag has been cleared, enabling it afterwards does not raise `irq_o`.
- R11: `bus_rdata` shows the flags (flag k in bit k) while `bus_rd` is high with address 0, and is zero for every other access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 status, 1 data, others unused |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 4 | Write data, one bit per flag |
| bus_rdata | output | 4 | Read data, combinational from the flags |
| evt_i | input | 4 | Hardware event pulses, one per flag |
| en_i | input | 4 | Interrupt enable, one per flag |
| ibit_i | input | 1 | Global interrupt mask, high blocks the request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checker assumes that reset is held low across the first clock edges and that the bus address, strobes and data are at known values whenever a strobe is high, with one address per cycle so a status access and a data access never coincide. The bench drives every input at the falling clock edge from defined values, keeps reset low for several cycles before any access, and issues at most one bus access per cycle, so the properties on flag setting, status writes and read data only ever see legal bus traffic.

// File: rtl/isf_pkg.sv
package isf_pkg;

    // State kept for one flag: the flag itself and whether a status read armed it.
    typedef struct packed {
        logic flag;
        logic arm;
    } cell_t;

    // Decoded bus activity for one cycle.
    typedef struct packed {
        logic stat_rd;
        logic stat_wr;
        logic data_acc;
    } bus_ev_t;

endpackage

// File: rtl/isf_bus_decode.sv
module isf_bus_decode
    import isf_pkg::*;
#(
    parameter int AW        = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output bus_ev_t       ev
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] DATA_A = AW'(DATA_ADDR);

    always_comb begin
        ev          = '0;
        ev.stat_rd  = rd && (addr == STAT_A);
        ev.stat_wr  = wr && (addr == STAT_A);
        ev.data_acc = (rd || wr) && (addr == DATA_A);
    end
endmodule

// File: rtl/isf_flag_cell.sv
module isf_flag_cell
    import isf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    evt,
    input  bus_ev_t ev,
    input  logic    wbit,
    output logic    flag_o
);
    cell_t st_d, st_q;
    logic  clr;

    always_comb begin
        st_d = st_q;
        // Either clear path; a simultaneous event overrides both.
        clr       = (ev.stat_wr & ~wbit) | (ev.data_acc & st_q.arm);
        st_d.flag = (st_q.flag & ~clr) | evt;
        if (ev.stat_rd) begin
            st_d.arm = st_q.flag;
        end else if (ev.data_acc) begin
            st_d.arm = 1'b0;
        end else begin
            st_d.arm = st_q.arm;
        end
        // An arm never outlives the flag it was taken from.
        st_d.arm = st_d.arm & st_d.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/isf_irq_gate.sv
module isf_irq_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    input  logic         ibit,
    output logic         irq
);
    always_comb begin
        irq = ~ibit & (|(flags & en));
    end
endmodule

// File: rtl/isf_status_flags.sv
module isf_status_flags
    import isf_pkg::*;
#(
    parameter int  N_FLAG    = 4,
    parameter int  N_REG     = 4,
    parameter int  STAT_ADDR = 0,
    parameter int  DATA_ADDR = 1,
    localparam int AW        = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [N_FLAG-1:0] bus_wdata,
    output logic [N_FLAG-1:0] bus_rdata,
    input  logic [N_FLAG-1:0] evt_i,
    input  logic [N_FLAG-1:0] en_i,
    input  logic              ibit_i,
    output logic              irq_o
);
    bus_ev_t           bev;
    logic [N_FLAG-1:0] flag_vec;

    isf_bus_decode #(
        .AW        (AW),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .ev   (bev)
    );

    for (genvar k = 0; k < N_FLAG; k++) begin : g_cell
        isf_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_i[k]),
            .ev     (bev),
            .wbit   (bus_wdata[k]),
            .flag_o (flag_vec[k])
        );
    end

    isf_irq_gate #(.N(N_FLAG)) u_gate (
        .flags (flag_vec),
        .en    (en_i),
        .ibit  (ibit_i),
        .irq   (irq_o)
    );

    always_comb begin
        bus_rdata = bev.stat_rd ? flag_vec : '0;
    end
endmodule

// File: rtl/isf_status_flags_chk.sv
module isf_status_flags_chk #(
    parameter int N_FLAG    = 4,
    parameter int AW        = 2,
    parameter int STAT_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [N_FLAG-1:0] bus_wdata,
    input logic [N_FLAG-1:0] bus_rdata,
    input logic [N_FLAG-1:0] evt_i,
    input logic [N_FLAG-1:0] en_i,
    input logic              ibit_i,
    input logic              irq_o,
    input logic [N_FLAG-1:0] flag_vec
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    // R2 R9
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flag_vec & $past(evt_i)) == $past(evt_i)));

    // R5
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> ((flag_vec & ~$past(flag_vec) & ~$past(evt_i)) == '0));

    // R5
    stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == STAT_A) |=>
        (flag_vec == (($past(flag_vec) & $past(bus_wdata)) | $past(evt_i))));

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ibit_i |-> !irq_o);

    // R3
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(flag_vec & en_i)));

    // R4
    irq_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ibit_i && (|(flag_vec & en_i))) |-> irq_o);

    // R11
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_A) |-> (bus_rdata == flag_vec));
endmodule

bind isf_status_flags isf_status_flags_chk #(
    .N_FLAG    (N_FLAG),
    .AW        (AW),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .en_i      (en_i),
    .ibit_i    (ibit_i),
    .irq_o     (irq_o),
    .flag_vec  (flag_vec)
);

// File: tb/sim_isf_status_flags.sv
module sim_isf_status_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic [3:0] evt_i = '0;
    logic [3:0] en_i = '0;
    logic       ibit_i = 1'b0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    isf_status_flags u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt_i),
        .en_i      (en_i),
        .ibit_i    (ibit_i),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [1:0] ad;
        logic [3:0] wd;
        logic [3:0] ev;
        logic [3:0] en;
        logic       ib;
        logic [3:0] xr;
        logic       xi;
        logic [3:0] rq;
    } vec_t;

    // Expected rdata/irq reflect the state before the clock edge of each row.
    localparam vec_t TBL [32] = '{
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h0,1'b0,4'd1},  // R1 idle after reset
        '{1'b0,1'b0,2'd0,4'h0,4'h1,4'h0,1'b0,4'h0,1'b0,4'd2},  // R2 event 0
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h1,1'b0,4'd4},  // R4 status read, enable low
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'h1,1'b1,4'h0,1'b0,4'd4},  // R4 masked by I
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'h1,1'b0,4'h0,1'b1,4'd3},  // R3 request
        '{1'b0,1'b1,2'd1,4'h0,4'h0,4'h1,1'b0,4'h0,1'b1,4'd6},  // R6 data write
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h1,1'b0,4'h0,1'b0,4'd6},  // R6 flag gone
        '{1'b0,1'b0,2'd0,4'h0,4'h6,4'h0,1'b0,4'h0,1'b0,4'd2},  // R2 events 1,2
        '{1'b0,1'b1,2'd0,4'hF,4'h0,4'h0,1'b0,4'h0,1'b0,4'd5},  // R5 write ones
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h6,1'b0,4'd5},  // R5 unchanged
        '{1'b0,1'b0,2'd0,4'h0,4'h8,4'h0,1'b0,4'h0,1'b0,4'd7},  // R7 late event
        '{1'b0,1'b1,2'd0,4'hF,4'h0,4'h0,1'b0,4'h0,1'b0,4'd6},  // R6 access between
        '{1'b1,1'b0,2'd1,4'h0,4'h0,4'h0,1'b0,4'h0,1'b0,4'd11}, // R11 data read zero
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h8,1'b0,4'd7},  // R7 late flag kept
        '{1'b0,1'b1,2'd0,4'h7,4'h0,4'h0,1'b0,4'h0,1'b0,4'd5},  // R5 clear bit 3
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h0,1'b0,4'd5},  // R5 all clear
        '{1'b0,1'b0,2'd0,4'h0,4'h1,4'h0,1'b0,4'h0,1'b0,4'd2},  // R2 event 0
        '{1'b1,1'b0,2'd1,4'h0,4'h0,4'h0,1'b0,4'h0,1'b0,4'd8},  // R8 unarmed data read
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h1,1'b0,4'd8},  // R8 flag kept
        '{1'b0,1'b1,2'd0,4'hE,4'h1,4'h0,1'b0,4'h0,1'b0,4'd9},  // R9 write clear vs set
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h1,1'b0,4'd9},  // R9 set won
        '{1'b1,1'b0,2'd1,4'h0,4'h1,4'h0,1'b0,4'h0,1'b0,4'd9},  // R9 sequence clear vs set
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h0,1'b0,4'h1,1'b0,4'd9},  // R9 set won
        '{1'b0,1'b1,2'd0,4'h0,4'h0,4'h0,1'b0,4'h0,1'b0,4'd10}, // R10 clear while pending
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'hF,1'b0,4'h0,1'b0,4'd10}, // R10 no request
        '{1'b0,1'b0,2'd0,4'h0,4'h2,4'hF,1'b1,4'h0,1'b0,4'd4},  // R4 event under I
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'hF,1'b1,4'h0,1'b0,4'd4},  // R4 still masked
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'hF,1'b0,4'h0,1'b1,4'd4},  // R4 I lowered
        '{1'b1,1'b0,2'd2,4'h0,4'h0,4'h2,1'b0,4'h0,1'b1,4'd11}, // R11 unused address
        '{1'b1,1'b0,2'd0,4'h0,4'h0,4'h2,1'b0,4'h2,1'b1,4'd6},  // R6 status read
        '{1'b0,1'b1,2'd1,4'h0,4'h0,4'h2,1'b0,4'h0,1'b1,4'd6},  // R6 data write
        '{1'b0,1'b0,2'd0,4'h0,4'h0,4'hF,1'b0,4'h0,1'b0,4'd6}   // R6 request gone
    };

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic [1:0] ad,
                         input logic [3:0] wd, input logic [3:0] ev,
                         input logic [3:0] en, input logic ib);
        @(negedge clk);
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = ad;
        bus_wdata = wd;
        evt_i     = ev;
        en_i      = en;
        ibit_i    = ib;
        #1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 32; i++) begin
            drive(TBL[i].rd, TBL[i].wr, TBL[i].ad, TBL[i].wd, TBL[i].ev, TBL[i].en, TBL[i].ib);
            check($sformatf("R%0d row %0d rdata", TBL[i].rq, i), bus_rdata, TBL[i].xr);
            check($sformatf("R%0d row %0d irq", TBL[i].rq, i), {3'b0, irq_o}, {3'b0, TBL[i].xi});
        end

        // R2 and R5 on every bit position.
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 2'd0, 4'h0, 4'(1 << k), 4'h0, 1'b0);
            drive(1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 1'b0);
            check("R2 walk set", bus_rdata, 4'(1 << k));
            drive(1'b0, 1'b1, 2'd0, ~4'(1 << k), 4'h0, 4'h0, 1'b0);
            drive(1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 1'b0);
            check("R5 walk clear", bus_rdata, 4'h0);
        end

        // R1: reset in mid-operation drops all flags.
        drive(1'b0, 1'b0, 2'd0, 4'h0, 4'hF, 4'h0, 1'b0);
        drive(1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'hF, 1'b0);
        check("R1 before reset irq", {3'b0, irq_o}, 4'h1);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'hF, 1'b0);
        drive(1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'hF, 1'b0);
        rst_n = 1'b1;
        check("R1 after reset irq", {3'b0, irq_o}, 4'h0);
        drive(1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 4'hF, 1'b0);
        check("R1 after reset flags", bus_rdata, 4'h0);

        drive(1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 1'b0);
        done = 1'b1;
        finish_run();
    end
endmodule